// File: doc/BRIEF.md
# I2C Slave Engine with Coded Status Reporting

This block is a byte-level I2C slave for a controller that sits on a shared two-wire bus. It watches the synchronised SCL and SDA lines for START, repeated START and STOP. It decodes the first byte after a START as a 7-bit address plus a direction bit. On a match it acknowledges the address and then acts as a slave receiver (direction 0) or a slave transmitter (direction 1).

Every significant bus event sets an interrupt flag and loads a coded status byte. While the flag is set, the block holds SCL low once SCL is low. Software reads the status, moves the data, and writes 0 to the flag bit to let the bus continue. An acknowledge-enable bit controls two things. It lets the block answer its own address and the general call. Clearing it also makes the block NACK the next received byte, or mark the next transmitted byte as the last. A separate input reports that the block has just lost arbitration, so that the address codes show this.

Register map (2-bit register address):
- 0: own address, with the address in bits 7:1 and the general-call enable in bit 0.
- 1: control, with bit 0 enable, bit 1 acknowledge-enable and bit 2 interrupt flag.
- 2: data.
- 3: status, read-only.

Top module: `i2c_slave_status`

## Requirements
- R1: After reset, all four registers read 00h except status, which reads F8h. The interrupt flag is 0 and neither SCL nor SDA is driven. Whenever the flag is clear, status reads F8h.
- R2: An address byte whose bits 7:1 equal own-address bits 7:1 (and are not zero) is acknowledged by pulling SDA low during the ninth clock. This happens only while enable and acknowledge-enable are both 1. After the ninth SCL falling edge the flag is set, with status 60h for direction 0 or A8h for direction 1.
- R3: Address byte 00h (address 0, direction 0) is acknowledged with status 70h only when own-address bit 0 is 1. Otherwise it gets no ACK and the flag stays 0.
- R4: An address that matches neither the own address nor an enabled general call gets no ACK, and the flag stays 0.
- R5: In receiver mode each byte is shifted in MSB first and copied to the data register. When acknowledge-enable is 1 the byte is ACKed, and the flag is set with status 80h (90h after a general call).
- R6: A byte received while acknowledge-enable is 0 is NACKed and reported as 88h (98h after a general call). After this the block ignores the bus until the next START.
- R7: While acknowledge-enable is 0 the own address is not acknowledged. Setting the bit again makes the next own-address byte match, with no reset in between.
- R8: If the arbitration-lost input is 1 when an address matches, the codes are 68h (own address, write), 78h (general call) and B0h (own address, read).
- R9: In transmitter mode the data register is shifted out MSB first, and SDA changes only while SCL is low. A master ACK gives B8h while acknowledge-enable is 1 and C8h while it is 0. A master NACK gives C0h. After C0h or C8h, SDA is released and no further flag is raised before the next START.
- R10: A STOP or repeated START while addressed as a receiver sets the flag with status A0h.
- R11: While the flag is set and SCL is low, SCL is held low. Writing control with bit 2 = 1 leaves the flag set. Writing bit 2 = 0 clears the flag and releases SCL.
- R12: While enable is 0, the block drives neither line and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| arb_lost_i | input | 1 | Arbitration was just lost by the master side |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench goes after the general-call address with the enable bit clear. A design that treats address 0 like any other own address would acknowledge it. It clears acknowledge-enable in the middle of a transfer. A design that samples the bit too late would still ACK that byte and keep raising flags afterwards. It ends transmitter runs both with a master NACK and with acknowledge-enable cleared before the last byte; mixing up C0h and C8h, or failing to release SDA, shows up in the status and in the bytes the master reads back. It also issues a repeated START in the middle of a receive and tries to set the flag by writing 1. A design that missed A0h, or that released the clock on any control write, would stall the bus or let the master run ahead.

// File: rtl/i2c_slv_pkg.sv
// Shared state encoding and status codes of the I2C slave engine.
package i2c_slv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
    } slv_state_e;

    localparam logic [7:0] SC_OWN_W    = 8'h60;
    localparam logic [7:0] SC_OWN_W_AL = 8'h68;
    localparam logic [7:0] SC_GC       = 8'h70;
    localparam logic [7:0] SC_GC_AL    = 8'h78;
    localparam logic [7:0] SC_RX_ACK   = 8'h80;
    localparam logic [7:0] SC_RX_NACK  = 8'h88;
    localparam logic [7:0] SC_GRX_ACK  = 8'h90;
    localparam logic [7:0] SC_GRX_NACK = 8'h98;
    localparam logic [7:0] SC_END      = 8'hA0;
    localparam logic [7:0] SC_OWN_R    = 8'hA8;
    localparam logic [7:0] SC_OWN_R_AL = 8'hB0;
    localparam logic [7:0] SC_TX_ACK   = 8'hB8;
    localparam logic [7:0] SC_TX_NACK  = 8'hC0;
    localparam logic [7:0] SC_TX_LAST  = 8'hC8;
    localparam logic [7:0] SC_IDLE     = 8'hF8;
endpackage

// File: rtl/i2c_bus_mon.sv
// Bus monitor: synchronises SCL and SDA through SYNC_STAGES flops and
// reports SCL edges plus START and STOP conditions as one-cycle pulses.
// Assumes the bus is far slower than clk (several clocks per SCL phase).
module i2c_bus_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_ff, sda_ff;
    logic         scl_p, sda_p;

    // Synchroniser chains, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
            for (int i = 1; i <= TOP; i++) begin
                scl_ff[i] <= scl_ff[i-1];
                sda_ff[i] <= sda_ff[i-1];
            end
        end
    end

    assign scl_s = scl_ff[TOP];
    assign sda_s = sda_ff[TOP];

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_slv_fsm.sv
// Byte engine: address match, receive and transmit shifting, ACK drive
// and status event generation. Rising SCL edges are counted so that the
// fall that ends a START is never taken for a data bit. Events are
// raised on the falling edge that closes the ACK clock.
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ack_en,
    input  logic [DW-2:0] own_addr,
    input  logic          gc_en,
    input  logic          arb_lost,
    input  logic          flag_clr,
    input  logic [DW-1:0] dreg,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          sda_oe,
    output logic          ev_valid,
    output logic [7:0]    ev_code,
    output logic          rx_valid,
    output logic [DW-1:0] rx_byte
);
    localparam int CW = $clog2(DW + 2);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW);
    localparam logic [CW-1:0] ACK_BIT  = CW'(DW + 1);

    slv_state_e    state;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh, tsh;
    logic          gc_q, rw_q, al_q, ack_q, mack_q;
    logic          own_hit, gc_hit;

    assign own_hit = ack_en && (sh[DW-1:1] == own_addr) && (sh[DW-1:1] != '0);
    assign gc_hit  = ack_en && gc_en && (sh[DW-1:1] == '0) && !sh[0];

    // Bus-phase sequencing, bit counting and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; cnt <= '0; sh <= '0; tsh <= '1;
            gc_q <= 1'b0; rw_q <= 1'b0; al_q <= 1'b0;
            ack_q <= 1'b0; mack_q <= 1'b0;
        end else if (!en) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (start_det) begin
            state <= ST_ADDR;
            cnt   <= '0;
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else begin
            if (flag_clr && state == ST_TX) tsh <= dreg;
            if (scl_rise && state != ST_IDLE) begin
                cnt <= cnt + 1'b1;
                if (state == ST_ADDR || state == ST_RX) sh <= {sh[DW-2:0], sda_s};
                if (state == ST_TACK) mack_q <= ~sda_s;
            end
            if (scl_fall) begin
                unique case (state)
                    ST_ADDR: if (cnt == LAST_BIT) begin
                        if (own_hit || gc_hit) begin
                            state <= ST_AACK;
                            gc_q  <= gc_hit;
                            rw_q  <= sh[0];
                            al_q  <= arb_lost;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_AACK: if (cnt == ACK_BIT) begin
                        state <= rw_q ? ST_TX : ST_RX;
                        cnt   <= '0;
                    end
                    ST_RX: if (cnt == LAST_BIT) begin
                        state <= ST_RACK;
                        ack_q <= ack_en;
                    end
                    ST_RACK: if (cnt == ACK_BIT) begin
                        state <= ack_q ? ST_RX : ST_IDLE;
                        cnt   <= '0;
                    end
                    ST_TX: begin
                        tsh <= {tsh[DW-2:0], 1'b1};
                        if (cnt == LAST_BIT) state <= ST_TACK;
                    end
                    ST_TACK: if (cnt == ACK_BIT) begin
                        state <= (mack_q && ack_en) ? ST_TX : ST_IDLE;
                        cnt   <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Event and status code selection for the register side.
    always_comb begin
        ev_valid = 1'b0;
        ev_code  = SC_IDLE;
        rx_valid = 1'b0;
        rx_byte  = sh;
        if (en) begin
            if ((start_det || stop_det) && state == ST_RX) begin
                ev_valid = 1'b1;
                ev_code  = SC_END;
            end else if (scl_fall && !start_det && !stop_det) begin
                if (state == ST_RX && cnt == LAST_BIT) rx_valid = 1'b1;
                if (state == ST_AACK && cnt == ACK_BIT) begin
                    ev_valid = 1'b1;
                    if (rw_q)      ev_code = al_q ? SC_OWN_R_AL : SC_OWN_R;
                    else if (gc_q) ev_code = al_q ? SC_GC_AL : SC_GC;
                    else           ev_code = al_q ? SC_OWN_W_AL : SC_OWN_W;
                end
                if (state == ST_RACK && cnt == ACK_BIT) begin
                    ev_valid = 1'b1;
                    if (gc_q) ev_code = ack_q ? SC_GRX_ACK : SC_GRX_NACK;
                    else      ev_code = ack_q ? SC_RX_ACK : SC_RX_NACK;
                end
                if (state == ST_TACK && cnt == ACK_BIT) begin
                    ev_valid = 1'b1;
                    if (!mack_q)     ev_code = SC_TX_NACK;
                    else if (ack_en) ev_code = SC_TX_ACK;
                    else             ev_code = SC_TX_LAST;
                end
            end
        end
    end

    // SDA pull-down: address ACK, data ACK, transmit bits.
    assign sda_oe = (state == ST_AACK) || (state == ST_RACK && ack_q) ||
                    (state == ST_TX && !tsh[DW-1]);

    // R9
    sda_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && scl_s && $past(scl_s) && !$past(start_det || stop_det))
        |-> $stable(sda_oe));

    // R12
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sda_oe);
endmodule

// File: rtl/i2c_slave_status.sv
// Top: register file (own address, control, data, status), interrupt
// flag and SCL stretching around the bus monitor and byte engine.
// Assumes open-drain pads outside: an *_oe_o of 1 pulls the line low.
module i2c_slave_status
    import i2c_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe_o,
    output logic          sda_oe_o,
    input  logic          arb_lost_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [1:0]    rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          irq_o
);
    localparam logic [1:0] RA_OWN = 2'd0, RA_CTL = 2'd1, RA_DAT = 2'd2, RA_STA = 2'd3;

    logic [DW-1:0] own_q, dat_q;
    logic [7:0]    sta_q;
    logic          en_q, acken_q, flag_q, stretch_q;
    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          ctl_wr, flag_clr, ev_valid, rx_valid;
    logic [7:0]    ev_code;
    logic [DW-1:0] rx_byte;

    i2c_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign ctl_wr   = wr_en_i && wr_addr_i == RA_CTL;
    assign flag_clr = ctl_wr && !wr_data_i[2] && flag_q;

    i2c_slv_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .ack_en(acken_q),
        .own_addr(own_q[DW-1:1]), .gc_en(own_q[0]), .arb_lost(arb_lost_i),
        .flag_clr(flag_clr), .dreg(dat_q), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_oe(sda_oe_o), .ev_valid(ev_valid),
        .ev_code(ev_code), .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '0; en_q <= 1'b0; acken_q <= 1'b0;
        end else if (wr_en_i) begin
            if (wr_addr_i == RA_OWN) own_q <= wr_data_i;
            if (ctl_wr) begin
                en_q    <= wr_data_i[0];
                acken_q <= wr_data_i[1];
            end
        end
    end

    // Data register: a received byte takes priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                            dat_q <= '0;
        else if (rx_valid)                     dat_q <= rx_byte;
        else if (wr_en_i && wr_addr_i == RA_DAT) dat_q <= wr_data_i;
    end

    // Interrupt flag and status code; a bus event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0; sta_q <= SC_IDLE;
        end else if (ev_valid) begin
            flag_q <= 1'b1; sta_q <= ev_code;
        end else if (ctl_wr && !wr_data_i[2]) begin
            flag_q <= 1'b0; sta_q <= SC_IDLE;
        end
    end

    // Clock stretch: engage once SCL is low while the flag is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) stretch_q <= 1'b0;
        else        stretch_q <= flag_q && (stretch_q || !scl_s);
    end

    assign scl_oe_o = stretch_q && flag_q;
    assign irq_o    = flag_q;

    // Register read multiplexer.
    always_comb begin
        unique case (rd_addr_i)
            RA_OWN:  rd_data_o = own_q;
            RA_CTL:  rd_data_o = DW'({flag_q, acken_q, en_q});
            RA_DAT:  rd_data_o = dat_q;
            default: rd_data_o = DW'(sta_q);
        endcase
    end

    // R11
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !scl_s) |=> (scl_oe_o || !flag_q));

    // R2
    code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (sta_q != SC_IDLE));
endmodule

// File: tb/i2c_slave_status_bench.sv
// Bench: an open-drain bus model with a bit-level master driven from tasks,
// software register accesses, directed corner cases and seeded random runs.
module i2c_slave_status_bench;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1, arb = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0, rd_data;
    logic       scl_oe, sda_oe, irq;
    logic       scl_line, sda_line;
    int         total = 0, fails = 0;
    logic [6:0] own7;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_slave_status u_i2c_slave_status (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .arb_lost_i(arb),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    function automatic logic [7:0] exp_addr(input logic rw, input logic gc, input logic al);
        if (rw) return al ? 8'hB0 : 8'hA8;
        if (gc) return al ? 8'h78 : 8'h70;
        return al ? 8'h68 : 8'h60;
    endfunction
    function automatic logic [7:0] exp_rx(input logic gc, input logic ack);
        if (gc) return ack ? 8'h90 : 8'h98;
        return ack ? 8'h80 : 8'h88;
    endfunction
    function automatic logic [7:0] exp_tx(input logic mack, input logic acken);
        if (!mack) return 8'hC0;
        return acken ? 8'hB8 : 8'hC8;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic qw(); repeat (Q) @(negedge clk); endtask
    task automatic sw_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask
    task automatic sw_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_addr = a; #1; d = rd_data;
    endtask
    task automatic expect_flag(input string req, input logic [7:0] code);
        logic [7:0] s;
        qw(); chk(req, {7'd0, irq}, 8'd1);
        sw_rd(2'd3, s); chk(req, s, code);
    endtask
    task automatic expect_none(input string req);
        qw(); chk(req, {7'd0, irq}, 8'd0);
    endtask
    task automatic clr(); sw_wr(2'd1, 8'h03); endtask

    task automatic scl_up();
        scl_m = 1'b1;
        while (!scl_line) @(negedge clk);
    endtask
    task automatic m_clk(input logic b, output logic s);
        qw(); sda_m = b; qw(); scl_up(); qw(); s = sda_line; qw(); scl_m = 1'b0;
    endtask
    task automatic m_start(); qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; endtask
    task automatic m_rstart(); qw(); sda_m = 1'b1; qw(); scl_up(); qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; endtask
    task automatic m_stop(); qw(); sda_m = 1'b0; qw(); scl_up(); qw(); sda_m = 1'b1; qw(); endtask
    task automatic m_write(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_clk(b[i], s);
        m_clk(1'b1, s);
        ack = ~s;
    endtask
    task automatic m_read(output logic [7:0] b, input logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin m_clk(1'b1, s); b[i] = s; end
        m_clk(~ack, s);
    endtask

    task automatic do_write(input logic [6:0] a, input logic gc, input int n, input logic al);
        logic ack; logic [7:0] d, x;
        arb = al; m_start(); m_write({a, 1'b0}, ack); arb = 1'b0;
        chk(gc ? "R3" : "R2", {7'd0, ack}, 8'd1);
        expect_flag(al ? "R8" : "R2", exp_addr(1'b0, gc, al)); clr();
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            m_write(d, ack); chk("R5", {7'd0, ack}, 8'd1);
            expect_flag("R5", exp_rx(gc, 1'b1));
            sw_rd(2'd2, x); chk("R5", x, d); clr();
        end
        m_stop(); expect_flag("R10", 8'hA0); clr();
    endtask

    task automatic do_read(input logic [6:0] a, input int n, input logic al, input logic c8);
        logic ack, last; logic [7:0] d, got;
        arb = al; m_start(); m_write({a, 1'b1}, ack); arb = 1'b0;
        chk("R2", {7'd0, ack}, 8'd1);
        expect_flag(al ? "R8" : "R2", exp_addr(1'b1, 1'b0, al));
        for (int i = 0; i < n; i++) begin
            last = (i == n - 1);
            d = 8'($urandom);
            sw_wr(2'd2, d);
            sw_wr(2'd1, (last && c8) ? 8'h01 : 8'h03);
            m_read(got, !last || c8);
            chk("R9", got, d);
            expect_flag("R9", exp_tx(!last || c8, !(last && c8)));
        end
        clr(); m_stop(); expect_none("R9");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] v; logic ack;
        v = 8'($urandom(32'd20240611));
        repeat (4) @(negedge clk); rst_n = 1'b1; @(negedge clk);
        // R1: reset state
        sw_rd(2'd3, v); chk("R1", v, 8'hF8);
        sw_rd(2'd1, v); chk("R1", v, 8'h00);
        sw_rd(2'd0, v); chk("R1", v, 8'h00);
        sw_rd(2'd2, v); chk("R1", v, 8'h00);
        chk("R1", {6'd0, scl_oe, sda_oe}, 8'd0);

        own7 = 7'($urandom_range(1, 126));
        sw_wr(2'd0, {own7, 1'b1}); sw_wr(2'd1, 8'h03);
        do_write(own7, 1'b0, 3, 1'b0);

        // R11 stretch, R10 repeated start
        m_start(); m_write({own7, 1'b0}, ack); expect_flag("R2", 8'h60);
        chk("R11", {7'd0, scl_oe}, 8'd1);
        sw_wr(2'd1, 8'h07); qw();
        chk("R11", {7'd0, irq}, 8'd1); chk("R11", {7'd0, scl_oe}, 8'd1);
        clr(); qw(); chk("R11", {7'd0, scl_oe}, 8'd0);
        sw_rd(2'd3, v); chk("R1", v, 8'hF8);
        m_rstart(); expect_flag("R10", 8'hA0); clr();
        m_write({own7, 1'b0}, ack); chk("R2", {7'd0, ack}, 8'd1);
        expect_flag("R2", 8'h60); clr();
        m_stop(); expect_flag("R10", 8'hA0); clr();

        // R3 general call accepted, R6 acknowledge-enable dropped mid-transfer
        m_start(); m_write(8'h00, ack); chk("R3", {7'd0, ack}, 8'd1);
        expect_flag("R3", 8'h70); clr();
        m_write(8'h5A, ack); expect_flag("R5", 8'h90);
        sw_wr(2'd1, 8'h01);
        m_write(8'hC3, ack); chk("R6", {7'd0, ack}, 8'd0);
        expect_flag("R6", 8'h98); sw_rd(2'd2, v); chk("R6", v, 8'hC3);
        sw_wr(2'd1, 8'h01);
        m_write(8'h33, ack); chk("R6", {7'd0, ack}, 8'd0); expect_none("R6");
        m_stop(); expect_none("R6");

        // R7 own address ignored while acknowledge-enable is 0, then resumed
        m_start(); m_write({own7, 1'b0}, ack); chk("R7", {7'd0, ack}, 8'd0);
        expect_none("R7"); m_stop();
        sw_wr(2'd1, 8'h03);
        m_start(); m_write({own7, 1'b0}, ack); chk("R7", {7'd0, ack}, 8'd1);
        expect_flag("R7", 8'h60); clr();
        m_stop(); expect_flag("R10", 8'hA0); clr();

        // R3 general call disabled, R4 foreign address
        sw_wr(2'd0, {own7, 1'b0});
        m_start(); m_write(8'h00, ack); chk("R3", {7'd0, ack}, 8'd0);
        expect_none("R3"); m_stop();
        m_start(); m_write({~own7, 1'b0}, ack); chk("R4", {7'd0, ack}, 8'd0);
        expect_none("R4"); m_stop();
        m_start(); m_write({own7 ^ 7'h01, 1'b1}, ack); chk("R4", {7'd0, ack}, 8'd0);
        expect_none("R4"); m_stop();
        sw_wr(2'd0, {own7, 1'b1});

        // R9 transmitter: NACK end and last-byte end
        do_read(own7, 3, 1'b0, 1'b0);
        do_read(own7, 2, 1'b0, 1'b1);

        // R8 arbitration-lost codes
        do_write(own7, 1'b0, 1, 1'b1);
        do_write(7'd0, 1'b1, 1, 1'b1);
        do_read(own7, 1, 1'b1, 1'b0);

        // R12 disabled block ignores the bus
        sw_wr(2'd1, 8'h02);
        m_start(); m_write({own7, 1'b0}, ack); chk("R12", {7'd0, ack}, 8'd0);
        expect_none("R12"); m_stop();
        sw_wr(2'd1, 8'h03);

        // Seeded random mix of transfers
        for (int it = 0; it < 8; it++) begin
            if ($urandom_range(0, 1) == 1)
                do_read(own7, $urandom_range(1, 4), 1'b0, 1'($urandom_range(0, 1)));
            else
                do_write(own7, 1'b0, $urandom_range(1, 4), 1'b0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule